// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block turns one routed interrupt request into a series of injections aimed at a set of processor targets. A request carries a destination byte, a mode bit that selects physical or logical addressing, a three-bit delivery mode, a vector and a trigger flag. Each of the `NUM_TGT` targets describes itself with a present flag, a physical ID and a logical ID. From these the block builds a bitmask of matching targets.

It then narrows that mask according to the delivery mode. Fixed delivery keeps every matching target. Lowest-priority delivery keeps exactly one target, chosen by a rotating round-robin pointer. Any other delivery mode keeps none.

Once accepted, the request is worked off one target per cycle. For each target the block outputs the target index, the vector and the trigger flag. A single `done` pulse follows the last injection. While it is working, the block accepts no new request. The interrupt acceptance logic on the processor side lies outside this block.

Top module: `irq_target_dispatch`

## Requirements
- R1: After reset, `reqReady` is high and `injValid` and `done` are low. The round-robin search for the first lowest-priority request starts at target 0.
- R2: In physical mode (`reqLogical`=0) with destination 0xFF, every target whose present flag is set is selected.
- R3: In physical mode with any destination other than 0xFF, only the lowest-index present target whose physical ID equals the destination is selected. A matching ID on an absent target is ignored.
- R4: In logical mode (`reqLogical`=1), destination 0 selects no target. Any other destination selects every present target for which the bitwise AND of the destination and its 8-bit logical ID is nonzero.
- R5: Delivery mode 3'b000 (fixed) injects into every selected target, one per cycle, in ascending index order. Injections start the cycle after acceptance, and each one carries the request's vector and trigger flag.
- R6: Delivery mode 3'b001 (lowest priority) injects into exactly one selected target. The search starts one index past the last target picked and wraps around. The pointer moves only when a target is picked.
- R7: When the selected mask is empty, no injection is made, and `done` pulses in the cycle after acceptance.
- R8: Delivery modes 3'b010 through 3'b111 make no injection and leave the round-robin pointer unchanged. `done` pulses in the cycle after acceptance.
- R9: `done` pulses for one cycle, in the cycle after the last injection. `reqReady` is low from the cycle after acceptance until `done`, and it is high again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle; a request is taken when this and `reqValid` are both high |
| reqDest | input | ID_W | Destination byte |
| reqLogical | input | 1 | 0 selects physical addressing, 1 selects logical addressing |
| reqMode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority, other values unsupported |
| reqVector | input | VEC_W | Interrupt vector |
| reqTrigLevel | input | 1 | Trigger flag passed through with each injection |
| tgtPresent | input | NUM_TGT | Per-target present flags |
| tgtPhysId | input | NUM_TGT*ID_W | Physical IDs; target i uses bits [i*ID_W +: ID_W] |
| tgtLogId | input | NUM_TGT*ID_W | Logical IDs; target i uses bits [i*ID_W +: ID_W] |
| injValid | output | 1 | An injection is presented this cycle |
| injTarget | output | $clog2(NUM_TGT) | Index of the target being injected |
| injVector | output | VEC_W | Vector of the injection |
| injTrigLevel | output | 1 | Trigger flag of the injection |
| done | output | 1 | One-cycle pulse marking the end of a request |

## Verification
The assertions assume that the target description inputs (`tgtPresent` and both ID buses) stay stable from the acceptance of a request until its `done`. One check, that every injected index is a present target, depends on this. The assertions also assume that a request offered while `reqReady` is low is simply held and not counted.

The stimulus sets the target description before it raises `reqValid`. It changes that description only after the scoreboard has consumed the `done` item of the previous request. It offers a request only in a cycle where `reqReady` is high, and withdraws it after one cycle.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  localparam logic [2:0] MODE_FIXED  = 3'b000;
  localparam logic [2:0] MODE_LOWPRI = 3'b001;

  typedef struct packed {
    logic loadReq;   // capture request and candidate mask
    logic stepInj;   // emit lowest pending target and retire it
    logic finish;    // end of request, pulse done
  } ctrlStrobe_t;

endpackage

// File: rtl/tgt_mask_resolve.sv
module tgt_mask_resolve #(
  parameter int NUM_TGT = 8,
  parameter int ID_W    = 8
) (
  input  logic [ID_W-1:0]         dest,
  input  logic                    logical,
  input  logic [NUM_TGT-1:0]      present,
  input  logic [NUM_TGT*ID_W-1:0] physId,
  input  logic [NUM_TGT*ID_W-1:0] logId,
  output logic [NUM_TGT-1:0]      mask
);

  logic [NUM_TGT-1:0] physHit;
  logic [NUM_TGT-1:0] logHit;
  logic [NUM_TGT-1:0] firstPhys;
  logic               isBroadcast;
  logic               destZero;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    assign physHit[i] = present[i] && (physId[i*ID_W +: ID_W] == dest);
    assign logHit[i]  = present[i] && (|(logId[i*ID_W +: ID_W] & dest));
  end

  // only the first physical match in index order survives
  always_comb begin
    logic found;
    found     = 1'b0;
    firstPhys = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (physHit[i] && !found) begin
        firstPhys[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign isBroadcast = &dest;
  assign destZero    = (dest == '0);

  always_comb begin
    if (logical)          mask = destZero ? '0 : logHit;
    else if (isBroadcast) mask = present;
    else                  mask = firstPhys;
  end

endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int VEC_W   = 8,
  localparam int TGT_W  = $clog2(NUM_TGT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_TGT-1:0] candMask,
  input  logic [2:0]         reqMode,
  input  logic [VEC_W-1:0]   reqVector,
  input  logic               reqTrigLevel,
  output logic               pendEmpty,
  output logic [TGT_W-1:0]   injTarget,
  output logic [VEC_W-1:0]   injVector,
  output logic               injTrigLevel
);

  logic [NUM_TGT-1:0] pendQ;
  logic [VEC_W-1:0]   vecQ;
  logic               trigQ;
  logic [TGT_W-1:0]   rrLastQ;

  logic [TGT_W-1:0]   rrIdx;
  logic               rrHit;
  logic [NUM_TGT-1:0] rrPick;
  logic [NUM_TGT-1:0] loadMask;
  logic [NUM_TGT-1:0] lowBit;

  // rotating search starting one past the last pick
  always_comb begin
    int idx;
    rrHit = 1'b0;
    rrIdx = rrLastQ;
    for (int k = 1; k <= NUM_TGT; k++) begin
      idx = (int'(rrLastQ) + k) % NUM_TGT;
      if (!rrHit && candMask[idx]) begin
        rrHit = 1'b1;
        rrIdx = TGT_W'(idx);
      end
    end
    rrPick = rrHit ? (NUM_TGT'(1) << rrIdx) : '0;
  end

  always_comb begin
    case (reqMode)
      MODE_FIXED:  loadMask = candMask;
      MODE_LOWPRI: loadMask = rrPick;
      default:     loadMask = '0;
    endcase
  end

  assign lowBit = pendQ & (~pendQ + NUM_TGT'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      vecQ    <= '0;
      trigQ   <= 1'b0;
      rrLastQ <= TGT_W'(NUM_TGT - 1);
    end else if (strobe.loadReq) begin
      pendQ <= loadMask;
      vecQ  <= reqVector;
      trigQ <= reqTrigLevel;
      if (reqMode == MODE_LOWPRI && rrHit) rrLastQ <= rrIdx;
    end else if (strobe.stepInj) begin
      pendQ <= pendQ & ~lowBit;
    end
  end

  always_comb begin
    injTarget = '0;
    for (int i = NUM_TGT - 1; i >= 0; i--) begin
      if (pendQ[i]) injTarget = TGT_W'(i);
    end
  end

  assign pendEmpty    = (pendQ == '0);
  assign injVector    = vecQ;
  assign injTrigLevel = trigQ;

endmodule

// File: rtl/dispatch_control.sv
module dispatch_control
  import irq_dispatch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        pendEmpty,
  output logic        reqReady,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t stateQ, stateD;

  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    reqReady = (stateQ == ST_IDLE);
    case (stateQ)
      ST_IDLE: if (reqValid) begin
        strobe.loadReq = 1'b1;
        stateD         = ST_RUN;
      end
      ST_RUN: if (!pendEmpty) begin
        strobe.stepInj = 1'b1;
      end else begin
        strobe.finish = 1'b1;
        stateD        = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/irq_target_dispatch.sv
module irq_target_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int ID_W    = 8,
  parameter int VEC_W   = 8,
  localparam int TGT_W  = $clog2(NUM_TGT)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ID_W-1:0]         reqDest,
  input  logic                    reqLogical,
  input  logic [2:0]              reqMode,
  input  logic [VEC_W-1:0]        reqVector,
  input  logic                    reqTrigLevel,
  input  logic [NUM_TGT-1:0]      tgtPresent,
  input  logic [NUM_TGT*ID_W-1:0] tgtPhysId,
  input  logic [NUM_TGT*ID_W-1:0] tgtLogId,
  output logic                    injValid,
  output logic [TGT_W-1:0]        injTarget,
  output logic [VEC_W-1:0]        injVector,
  output logic                    injTrigLevel,
  output logic                    done
);

  ctrlStrobe_t        strobe;
  logic               pendEmpty;
  logic [NUM_TGT-1:0] candMask;

  tgt_mask_resolve #(.NUM_TGT(NUM_TGT), .ID_W(ID_W)) u_resolve (
    .dest    (reqDest),
    .logical (reqLogical),
    .present (tgtPresent),
    .physId  (tgtPhysId),
    .logId   (tgtLogId),
    .mask    (candMask)
  );

  dispatch_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .pendEmpty (pendEmpty),
    .reqReady  (reqReady),
    .strobe    (strobe)
  );

  dispatch_datapath #(.NUM_TGT(NUM_TGT), .VEC_W(VEC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .candMask     (candMask),
    .reqMode      (reqMode),
    .reqVector    (reqVector),
    .reqTrigLevel (reqTrigLevel),
    .pendEmpty    (pendEmpty),
    .injTarget    (injTarget),
    .injVector    (injVector),
    .injTrigLevel (injTrigLevel)
  );

  assign injValid = strobe.stepInj;
  assign done     = strobe.finish;

endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker #(
  parameter int NUM_TGT = 8,
  parameter int ID_W    = 8,
  parameter int VEC_W   = 8,
  localparam int TGT_W  = $clog2(NUM_TGT)
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic [ID_W-1:0]    reqDest,
  input logic               reqLogical,
  input logic [2:0]         reqMode,
  input logic [NUM_TGT-1:0] tgtPresent,
  input logic               injValid,
  input logic [TGT_W-1:0]   injTarget,
  input logic [VEC_W-1:0]   injVector,
  input logic               done
);

  logic accepted;
  logic curFixed;

  assign accepted = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN)         curFixed <= 1'b1;
    else if (accepted) curFixed <= (reqMode == 3'b000);
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    injValid |-> !reqReady);  // R9
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!injValid && !reqReady));  // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);  // R9
  AST_ASCENDING_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (injValid && $past(injValid)) |-> (injTarget > $past(injTarget)));  // R5
  AST_SAME_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (injValid && $past(injValid)) |-> (injVector == $past(injVector)));  // R5
  AST_LOWPRI_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (injValid && $past(injValid)) |-> curFixed);  // R6
  AST_UNSUPPORTED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqMode[2:1] != 2'b00) |=> (done && !injValid));  // R8
  AST_LOGICAL_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqLogical && reqDest == '0) |=> (done && !injValid));  // R4
  AST_INJ_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    injValid |-> tgtPresent[injTarget]);  // R3

endmodule

bind irq_target_dispatch irq_dispatch_checker #(
  .NUM_TGT(NUM_TGT), .ID_W(ID_W), .VEC_W(VEC_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqDest    (reqDest),
  .reqLogical (reqLogical),
  .reqMode    (reqMode),
  .tgtPresent (tgtPresent),
  .injValid   (injValid),
  .injTarget  (injTarget),
  .injVector  (injVector),
  .done       (done)
);

// File: tb/test_irq_target_dispatch.sv
module test_irq_target_dispatch;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int IW = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [IW-1:0] reqDest = '0;
  logic          reqLogical = 1'b0;
  logic [2:0]    reqMode = '0;
  logic [VW-1:0] reqVector = '0;
  logic          reqTrigLevel = 1'b0;
  logic [NT-1:0] tgtPresent = '0;
  logic [NT*IW-1:0] tgtPhysId = '0;
  logic [NT*IW-1:0] tgtLogId = '0;
  logic          injValid;
  logic [2:0]    injTarget;
  logic [VW-1:0] injVector;
  logic          injTrigLevel;
  logic          done;

  int checks = 0;
  int errors = 0;
  int rrLast = NT - 1;

  int   expTgt[$];   // -1 marks the done item
  int   expVec[$];
  int   expTrig[$];
  string expTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_target_dispatch #(.NUM_TGT(NT), .ID_W(IW), .VEC_W(VW)) i_irq_target_dispatch (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqDest(reqDest), .reqLogical(reqLogical), .reqMode(reqMode),
    .reqVector(reqVector), .reqTrigLevel(reqTrigLevel),
    .tgtPresent(tgtPresent), .tgtPhysId(tgtPhysId), .tgtLogId(tgtLogId),
    .injValid(injValid), .injTarget(injTarget), .injVector(injVector),
    .injTrigLevel(injTrigLevel), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] modelMask(input logic [7:0] d, input logic lg);
    logic [NT-1:0] m = '0;
    if (lg) begin
      if (d != 0)
        for (int i = 0; i < NT; i++)
          if (tgtPresent[i] && ((tgtLogId[i*IW +: IW] & d) != 0)) m[i] = 1'b1;
    end else if (d == 8'hFF) begin
      m = tgtPresent;
    end else begin
      for (int i = 0; i < NT; i++)
        if (tgtPresent[i] && tgtPhysId[i*IW +: IW] == d) begin
          m[i] = 1'b1;
          break;
        end
    end
    return m;
  endfunction

  task automatic pushItem(input int t, input int v, input int tr, input string tag);
    expTgt.push_back(t); expVec.push_back(v); expTrig.push_back(tr); expTag.push_back(tag);
  endtask

  task automatic send(input logic [7:0] d, input logic lg, input logic [2:0] md,
                      input logic [7:0] vec, input logic tr, input string tag);
    logic [NT-1:0] m;
    m = modelMask(d, lg);
    if (md == 3'b000) begin
      for (int i = 0; i < NT; i++) if (m[i]) pushItem(i, vec, tr, tag);
    end else if (md == 3'b001) begin
      for (int k = 1; k <= NT; k++) begin
        int idx = (rrLast + k) % NT;
        if (m[idx]) begin
          pushItem(idx, vec, tr, tag);
          rrLast = idx;
          break;
        end
      end
    end
    pushItem(-1, 0, 0, tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqDest = d; reqLogical = lg; reqMode = md; reqVector = vec; reqTrigLevel = tr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9 busy after accept", int'(reqReady), 0);
    while (expTgt.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (injValid) begin
        if (expTgt.size() == 0 || expTgt[0] == -1) begin
          check(1'b0, "R5/R6 unexpected injection", int'(injTarget), -1);
          if (expTgt.size() != 0) begin
            void'(expTgt.pop_front()); void'(expVec.pop_front());
            void'(expTrig.pop_front()); void'(expTag.pop_front());
          end
        end else begin
          check(int'(injTarget) == expTgt[0], {expTag[0], " target"}, int'(injTarget), expTgt[0]);
          check(int'(injVector) == expVec[0], {expTag[0], " vector"}, int'(injVector), expVec[0]);
          check(int'(injTrigLevel) == expTrig[0], {expTag[0], " trigger"}, int'(injTrigLevel), expTrig[0]);
          void'(expTgt.pop_front()); void'(expVec.pop_front());
          void'(expTrig.pop_front()); void'(expTag.pop_front());
        end
      end
      if (done) begin
        if (expTgt.size() == 0 || expTgt[0] != -1) begin
          check(1'b0, "R9 early or stray done", 1, 0);
        end else begin
          check(1'b1, {expTag[0], " done"}, 1, 1);
          void'(expTgt.pop_front()); void'(expVec.pop_front());
          void'(expTrig.pop_front()); void'(expTag.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) begin
      tgtPhysId[i*IW +: IW] = 8'(8'h10 + i);
      tgtLogId[i*IW +: IW]  = 8'(1 << i);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    check(injValid == 1'b0, "R1 injValid", int'(injValid), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);

    // R2 broadcast, fixed
    tgtPresent = 8'b1011_0110;
    send(8'hFF, 1'b0, 3'b000, 8'h41, 1'b1, "R2 R5 broadcast fixed");

    // R3 first physical match only; absent target 1 also carries the ID
    tgtPresent = 8'b0100_1001;
    tgtPhysId[1*IW +: IW] = 8'h22;
    tgtPhysId[3*IW +: IW] = 8'h22;
    tgtPhysId[6*IW +: IW] = 8'h22;
    send(8'h22, 1'b0, 3'b000, 8'h52, 1'b0, "R3 first match");
    send(8'h55, 1'b0, 3'b000, 8'h53, 1'b0, "R3 R7 no match");

    // R4 logical addressing
    tgtPresent = 8'hFF;
    send(8'h00, 1'b1, 3'b000, 8'h60, 1'b1, "R4 R7 logical zero");
    send(8'h25, 1'b1, 3'b000, 8'h61, 1'b1, "R4 R5 logical flat");
    tgtPresent = 8'b1101_1111;
    send(8'hA4, 1'b1, 3'b000, 8'h62, 1'b0, "R4 logical absent skipped");

    // R1 R6 round robin from index 0
    tgtPresent = 8'hFF;
    for (int n = 0; n < 4; n++)
      send(8'hFF, 1'b1, 3'b001, 8'h70, 1'b0, "R1 R6 rotate");
    tgtPresent = 8'b0010_0100;
    send(8'hFF, 1'b0, 3'b001, 8'h71, 1'b1, "R6 skip gap");
    send(8'hFF, 1'b0, 3'b001, 8'h72, 1'b1, "R6 wrap");
    // R6 R7 empty mask leaves pointer unchanged
    send(8'h00, 1'b1, 3'b001, 8'h73, 1'b0, "R6 R7 empty lowpri");
    tgtPresent = 8'hFF;
    send(8'hFF, 1'b0, 3'b001, 8'h74, 1'b0, "R6 after empty");

    // R8 unsupported delivery modes, pointer untouched
    send(8'hFF, 1'b0, 3'b010, 8'h80, 1'b0, "R8 mode 2");
    send(8'hFF, 1'b0, 3'b111, 8'h81, 1'b1, "R8 mode 7");
    send(8'hFF, 1'b0, 3'b001, 8'h82, 1'b0, "R8 R6 pointer kept");

    repeat (3) @(negedge clk);
    check(expTgt.size() == 0, "R9 scoreboard drained", expTgt.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule